// File: doc/BRIEF.md
# Biphase Serial Frame Receiver

This block decodes a biphase-coded serial line into bytes. The line is sampled once per clock, and one bit cell lasts `OVS` clocks. Every cell has a transition at its centre. A logic 1 is sent as low then high, and a logic 0 as high then low. The receiver ignores the line until it sees a message opener. That opener is a run of logic-1 cells followed by the line being held high past the point where a mid-cell transition was due. After the opener, a line edge marks the cell timing.

Inside a message, data arrives in units of nine cells: one sync cell followed by eight data cells, least significant bit first. Even parity must hold across all nine cells. A good unit produces a one-cycle byte strobe with the eight data bits. A message ends normally when the line stays low through the cell where the next sync bit would start. Any other breach of the format aborts the message and produces a one-cycle error strobe with a type code. Every decoded cell is also presented on a serial data/clock pair, so an external checker can watch the raw bit stream.

Top module: `biphase_frame_rx`

## Requirements
- R1: The line is sampled every clock, and one cell is `OVS` samples long (default 8). A bit is decided at the transition that falls between `OVS-OVS/4` and `OVS+OVS/4` samples after the previous mid-cell transition. A rising transition gives 1 and a falling transition gives 0. Transitions arriving earlier than that window are cell-boundary transitions and carry no bit.
- R2: `rx_active` stays low until at least `START_ONES` (default 5) consecutive logic-1 cells are followed by a high line that misses the next mid-cell transition. After this opener, `rx_active` rises. The next line edge then sets the cell timing for the message.
- R3: Within a message, each unit is one sync cell followed by eight data cells. When a unit is accepted, `byte_done` pulses for one cycle. At that pulse, `byte_data` bit i holds the i-th data cell received after the sync cell.
- R4: Even parity must hold across the nine cells of a unit (sync plus data). If the count of ones is odd, the receiver pulses `error_strobe` with `error_code` = 2, does not pulse `byte_done`, and ends the message.
- R5: Within a unit, after the sync cell has been received, a mid-cell transition may be missing (no transition within `OVS+OVS/4` samples of the previous one). In that case the receiver pulses `error_strobe` with `error_code` = 1 and ends the message.
- R6: A missing mid-cell transition where a sync cell is due, with the line low, is the normal ending. `rx_active` falls and no error is reported.
- R7: A missing mid-cell transition where a sync cell is due, with the line high, is a bad ending. The receiver reports `error_code` = 3 and ends the message.
- R8: `error_strobe` lasts one cycle, and `rx_active` is already low in that cycle. `error_code` is then 1, 2 or 3. `byte_done` and `error_strobe` never pulse in the same cycle.
- R9: Within a message, every decoded cell, including the sync cell, gives one `ser_clk` pulse of one cycle, with the cell value on `ser_data`.
- R10: While `rx_disable` is high, the line is read as constant low. A message opener sent during that time is not detected.
- R11: Synchronous active-high `rst` clears the receiver: `rx_active`, `byte_done`, `error_strobe` and `ser_clk` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `OVS` cycles per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Biphase-coded serial line |
| rx_disable | input | 1 | Forces the line to read low while high |
| rx_active | output | 1 | High from opener detection until the message ends |
| ser_data | output | 1 | Value of the most recent decoded cell |
| ser_clk | output | 1 | One-cycle pulse per decoded cell within a message |
| byte_done | output | 1 | One-cycle strobe for an accepted unit |
| byte_data | output | 8 | Data byte, valid with `byte_done` |
| error_strobe | output | 1 | One-cycle strobe for a format error |
| error_code | output | 3 | Error type, valid with `error_strobe` |

## Verification
The bench sends openers with exactly and more than `START_ONES` logic-1 cells, and one with a cell too few. A design that miscounts the run would open a message that should be ignored, or reject a valid one. Sync and data values are chosen to give both even and odd parity over nine cells. A design that leaves out the sync cell from the parity would accept bad units or reject good ones. Both line levels are used in the sync slot, to separate a clean ending from error code 3. A quiet line is placed inside the data cells to confirm that it reports a code violation rather than an ending. Two-unit messages check that the cell counter wraps correctly. Finally, a full message is sent while `rx_disable` is high, to show the gate really blocks opener detection.

// File: rtl/bfrx_pkg.sv
package bfrx_pkg;

    typedef enum logic [1:0] {
        FS_HUNT   = 2'd0,
        FS_SYNC   = 2'd1,
        FS_ACTIVE = 2'd2
    } frame_state_t;

    typedef enum logic [2:0] {
        EC_NONE   = 3'd0,
        EC_CODE   = 3'd1,
        EC_PARITY = 3'd2,
        EC_ENDING = 3'd3
    } err_code_t;

    // Events produced by the cell decoder, consumed by the framer.
    typedef struct packed {
        logic bit_stb;   // mid-cell transition inside the timing window
        logic bit_val;   // decoded cell value (line level after transition)
        logic viol_stb;  // mid-cell transition missed
        logic viol_lvl;  // line level during the missed transition
        logic lock_stb;  // first edge after the line has been quiet
        logic lock_lvl;  // line level after that edge
    } cell_evt_t;

    function automatic logic code_is_legal(input logic [2:0] c);
        return (c == EC_CODE) || (c == EC_PARITY) || (c == EC_ENDING);
    endfunction

endpackage

// File: rtl/bfrx_sampler.sv
module bfrx_sampler (
    input  logic clk,
    input  logic rst,
    input  logic rx_line,
    input  logic rx_disable,
    output logic lvl,
    output logic edge_seen
);
    logic s_q;
    logic s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q    <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_q    <= rx_line & ~rx_disable;
            s_prev <= s_q;
        end
    end

    assign lvl       = s_q;
    assign edge_seen = s_q ^ s_prev;

endmodule

// File: rtl/bfrx_cell_decoder.sv
module bfrx_cell_decoder
    import bfrx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  logic      edge_seen,
    output cell_evt_t evt
);
    localparam int MID_MIN_I = OVS - OVS / 4;
    localparam int VIOL_AT_I = OVS + OVS / 4 + 1;
    localparam int CW        = $clog2(VIOL_AT_I + 1);
    localparam logic [CW-1:0] MID_MIN = CW'(MID_MIN_I);
    localparam logic [CW-1:0] VIOL_AT = CW'(VIOL_AT_I);
    localparam logic [CW-1:0] ONE     = CW'(1);

    // Samples elapsed since the last mid-cell reference; saturates at VIOL_AT.
    logic [CW-1:0] since_mid;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_mid <= VIOL_AT;
        end else if (edge_seen && since_mid >= MID_MIN) begin
            since_mid <= ONE;
        end else if (since_mid < VIOL_AT) begin
            since_mid <= since_mid + ONE;
        end
    end

    always_comb begin
        evt          = '0;
        evt.bit_stb  = edge_seen && (since_mid >= MID_MIN) && (since_mid < VIOL_AT);
        evt.bit_val  = lvl;
        evt.viol_stb = !edge_seen && (since_mid == VIOL_AT - ONE);
        evt.viol_lvl = lvl;
        evt.lock_stb = edge_seen && (since_mid >= VIOL_AT);
        evt.lock_lvl = lvl;
    end

    // R1: a decided cell is never followed by another decision one sample later
    a_r1_cell_spacing: assert property (@(posedge clk) disable iff (rst)
        evt.bit_stb |=> !evt.bit_stb && !evt.viol_stb);

    // R5: a missed transition is flagged once per quiet stretch
    a_r5_single_viol: assert property (@(posedge clk) disable iff (rst)
        evt.viol_stb |=> !evt.viol_stb && !evt.bit_stb);

endmodule

// File: rtl/bfrx_framer.sv
module bfrx_framer
    import bfrx_pkg::*;
#(
    parameter int DW         = 8,
    parameter int START_ONES = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  cell_evt_t     evt,
    output logic          rx_active,
    output logic          ser_data,
    output logic          ser_clk,
    output logic          byte_done,
    output logic [DW-1:0] byte_data,
    output logic          error_strobe,
    output logic [2:0]    error_code
);
    localparam int UNIT = DW + 1;
    localparam int IW   = $clog2(UNIT);
    localparam int OW   = $clog2(START_ONES + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(UNIT - 1);
    localparam logic [OW-1:0] ONES_REQ = OW'(START_ONES);

    frame_state_t    state;
    logic [OW-1:0]   ones;
    logic [IW-1:0]   idx;
    logic [UNIT-1:0] shreg;
    logic [UNIT-1:0] word;

    assign word      = {evt.bit_val, shreg[UNIT-1:1]};
    assign rx_active = (state != FS_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= FS_HUNT;
            ones         <= '0;
            idx          <= '0;
            shreg        <= '0;
            ser_data     <= 1'b0;
            ser_clk      <= 1'b0;
            byte_done    <= 1'b0;
            byte_data    <= '0;
            error_strobe <= 1'b0;
            error_code   <= EC_NONE;
        end else begin
            ser_clk      <= 1'b0;
            byte_done    <= 1'b0;
            error_strobe <= 1'b0;
            unique case (state)
                FS_HUNT: begin
                    if (evt.lock_stb) begin
                        ones <= evt.lock_lvl ? OW'(1) : '0;
                    end else if (evt.bit_stb) begin
                        if (!evt.bit_val)        ones <= '0;
                        else if (ones < ONES_REQ) ones <= ones + OW'(1);
                    end else if (evt.viol_stb) begin
                        ones <= '0;
                        if (evt.viol_lvl && ones >= ONES_REQ) state <= FS_SYNC;
                    end
                end
                FS_SYNC: begin
                    if (evt.lock_stb) begin
                        state <= FS_ACTIVE;
                        idx   <= '0;
                    end
                end
                FS_ACTIVE: begin
                    if (evt.bit_stb) begin
                        ser_clk  <= 1'b1;
                        ser_data <= evt.bit_val;
                        shreg    <= word;
                        if (idx == LAST_IDX) begin
                            idx <= '0;
                            if (^word) begin
                                error_strobe <= 1'b1;
                                error_code   <= EC_PARITY;
                                state        <= FS_HUNT;
                            end else begin
                                byte_done <= 1'b1;
                                byte_data <= word[UNIT-1:1];
                            end
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end else if (evt.viol_stb) begin
                        state <= FS_HUNT;
                        if (idx != '0) begin
                            error_strobe <= 1'b1;
                            error_code   <= EC_CODE;
                        end else if (evt.viol_lvl) begin
                            error_strobe <= 1'b1;
                            error_code   <= EC_ENDING;
                        end
                    end
                end
                default: state <= FS_HUNT;
            endcase
        end
    end

    // R8: an error has already closed the message
    a_r8_err_closes: assert property (@(posedge clk) disable iff (rst)
        error_strobe |-> !rx_active);

    // R8: only the three defined codes are reported
    a_r8_code_legal: assert property (@(posedge clk) disable iff (rst)
        error_strobe |-> code_is_legal(error_code));

    // R8: a unit is either accepted or rejected, never both
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(byte_done && error_strobe));

    // R3: accepted units only appear inside a message
    a_r3_byte_in_msg: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> rx_active);

    // R9: serial clock pulses come from cells decoded inside a message
    a_r9_serclk_in_msg: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $past(rx_active));

endmodule

// File: rtl/biphase_frame_rx.sv
module biphase_frame_rx
    import bfrx_pkg::*;
#(
    parameter int OVS        = 8,
    parameter int DW         = 8,
    parameter int START_ONES = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_line,
    input  logic          rx_disable,
    output logic          rx_active,
    output logic          ser_data,
    output logic          ser_clk,
    output logic          byte_done,
    output logic [DW-1:0] byte_data,
    output logic          error_strobe,
    output logic [2:0]    error_code
);
    logic      lvl;
    logic      edge_seen;
    cell_evt_t evt;

    bfrx_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .rx_disable(rx_disable),
        .lvl       (lvl),
        .edge_seen (edge_seen)
    );

    bfrx_cell_decoder #(.OVS(OVS)) u_decoder (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .edge_seen(edge_seen),
        .evt      (evt)
    );

    bfrx_framer #(.DW(DW), .START_ONES(START_ONES)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rx_active   (rx_active),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .byte_done   (byte_done),
        .byte_data   (byte_data),
        .error_strobe(error_strobe),
        .error_code  (error_code)
    );

    // R10: a gated line can never open a message
    a_r10_disable_blocks: assert property (@(posedge clk) disable iff (rst)
        (rx_disable && $past(rx_disable) && $past(rx_disable, 2)) |-> !$rose(rx_active));

endmodule

// File: tb/biphase_frame_rx_test.sv
`timescale 1ns/1ps
module biphase_frame_rx_test;
    localparam int OVS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b0;
    logic       rx_disable = 1'b0;
    logic       rx_active, ser_data, ser_clk, byte_done, error_strobe;
    logic [7:0] byte_data;
    logic [2:0] error_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    biphase_frame_rx #(.OVS(OVS), .DW(8), .START_ONES(5)) uut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .rx_disable(rx_disable),
        .rx_active(rx_active), .ser_data(ser_data), .ser_clk(ser_clk),
        .byte_done(byte_done), .byte_data(byte_data),
        .error_strobe(error_strobe), .error_code(error_code)
    );

    // Output monitor: only counts, sampled on the falling edge.
    int         n_bytes = 0, n_errs = 0, n_bits = 0, n_rises = 0;
    logic [7:0] last_byte = '0;
    logic [2:0] last_code = '0;
    logic [8:0] ser_sh = '0;
    logic       act_q = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_done)    begin n_bytes++; last_byte = byte_data; end
            if (error_strobe) begin n_errs++;  last_code = error_code; end
            if (ser_clk)      begin n_bits++;  ser_sh = {ser_data, ser_sh[8:1]}; end
            if (rx_active && !act_q) n_rises++;
            act_q = rx_active;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_line = v;
        end
    endtask

    task automatic send_cell(input logic b);
        put(~b, OVS / 2);
        put(b, OVS / 2);
    endtask

    task automatic send_start(input int n_ones);
        put(1'b0, 16);
        for (int i = 0; i < n_ones; i++) send_cell(1'b1);
        put(1'b1, OVS);
        put(1'b0, OVS / 2);
    endtask

    task automatic send_unit(input logic sync, input logic [7:0] d);
        send_cell(sync);
        for (int i = 0; i < 8; i++) send_cell(d[i]);
    endtask

    task automatic send_end(input logic lvl);
        put(lvl, 2 * OVS);
        put(1'b0, 3 * OVS);
    endtask

    // Stimulus/expectation table: {data[7:0], sync, end_high, code[2:0], byte_expected}
    localparam logic [13:0] VEC [8] = '{
        {8'h00, 1'b0, 1'b0, 3'd0, 1'b1},
        {8'hA5, 1'b0, 1'b0, 3'd0, 1'b1},
        {8'h01, 1'b1, 1'b0, 3'd0, 1'b1},
        {8'hFF, 1'b0, 1'b0, 3'd0, 1'b1},
        {8'h03, 1'b1, 1'b0, 3'd2, 1'b0},
        {8'h80, 1'b0, 1'b0, 3'd2, 1'b0},
        {8'h3C, 1'b0, 1'b1, 3'd3, 1'b1},
        {8'h7E, 1'b0, 1'b0, 3'd0, 1'b1}
    };

    int b0, e0, s0, r0;
    task automatic snap();
        b0 = n_bytes; e0 = n_errs; s0 = n_bits; r0 = n_rises;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check(rx_active == 1'b0, "R11 rx_active in reset", int'(rx_active), 0);
        check(byte_done == 1'b0 && error_strobe == 1'b0, "R11 strobes in reset",
              int'(byte_done | error_strobe), 0);
        @(negedge clk); rst = 1'b0;
        put(1'b0, 4);
        check(rx_active == 1'b0 && ser_clk == 1'b0, "R11 idle after reset",
              int'(rx_active | ser_clk), 0);

        // Table walk: R1 R2 R3 R4 R6 R7 R9
        for (int v = 0; v < 8; v++) begin
            logic [7:0] d;
            logic       sy, eh, xb;
            logic [2:0] xc;
            {d, sy, eh, xc, xb} = VEC[v];
            snap();
            send_start(5);
            send_unit(sy, d);
            send_end(eh);
            check(n_rises - r0 == 1, "R2 opener detected", n_rises - r0, 1);
            check(n_bytes - b0 == int'(xb), "R3/R4 byte count", n_bytes - b0, int'(xb));
            if (xb) check(last_byte == d, "R3 byte value", int'(last_byte), int'(d));
            check(n_errs - e0 == int'(xc != 0), "R4/R6/R7 error count", n_errs - e0, int'(xc != 0));
            if (xc != 0) check(last_code == xc, "R4/R7 error code", int'(last_code), int'(xc));
            check(n_bits - s0 == 9, "R9 ser_clk pulses", n_bits - s0, 9);
            check(ser_sh == {d, sy}, "R9 ser_data stream", int'(ser_sh), int'({d, sy}));
            check(rx_active == 1'b0, "R6 message closed", int'(rx_active), 0);
        end

        // R3 R9: two units in one message
        snap();
        send_start(5);
        send_unit(1'b0, 8'h5A);
        send_unit(1'b1, 8'h01);
        send_end(1'b0);
        check(n_bytes - b0 == 2, "R3 two units", n_bytes - b0, 2);
        check(last_byte == 8'h01, "R3 second byte", int'(last_byte), 1);
        check(n_errs == e0, "R6 clean two-unit end", n_errs - e0, 0);
        check(n_bits - s0 == 18, "R9 bits over two units", n_bits - s0, 18);

        // R2: more ones than required still opens
        snap();
        send_start(7);
        send_unit(1'b0, 8'h42);
        send_end(1'b0);
        check(n_bytes - b0 == 1 && last_byte == 8'h42, "R2 long run opener",
              int'(last_byte), 8'h42);

        // R2: one logic-1 cell short is ignored
        snap();
        send_start(4);
        send_unit(1'b0, 8'h00);
        send_end(1'b0);
        check(n_rises == r0, "R2 short run ignored", n_rises - r0, 0);
        check(n_bytes == b0 && n_errs == e0, "R2 nothing reported", n_bytes - b0 + n_errs - e0, 0);

        // R5: quiet line in the middle of the data cells
        snap();
        send_start(5);
        send_cell(1'b0);
        send_cell(1'b1);
        send_cell(1'b0);
        send_cell(1'b1);
        put(1'b0, 3 * OVS);
        check(n_errs - e0 == 1, "R5 violation reported", n_errs - e0, 1);
        check(last_code == 3'd1, "R5 code violation", int'(last_code), 1);
        check(n_bytes == b0 && rx_active == 1'b0, "R5 message aborted", int'(rx_active), 0);

        // R10: gated line
        snap();
        rx_disable = 1'b1;
        send_start(6);
        send_unit(1'b0, 8'h00);
        send_end(1'b0);
        check(n_rises == r0, "R10 opener blocked", n_rises - r0, 0);
        check(n_bytes == b0, "R10 no byte", n_bytes - b0, 0);
        rx_disable = 1'b0;
        put(1'b0, 8);

        // R8: error strobe lasts exactly one cycle (checked at the port)
        snap();
        send_start(5);
        send_unit(1'b1, 8'h00);
        put(1'b0, 1);
        check(n_errs - e0 == 1 && last_code == 3'd2, "R8 parity abort", int'(last_code), 2);
        check(error_strobe == 1'b0, "R8 one-cycle strobe", int'(error_strobe), 0);
        put(1'b0, 3 * OVS);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule